// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a two-wire memory's protocol engine and a plain synchronous byte memory. The protocol engine hands it address loads, data bytes, read requests and the start and stop events it decodes from the bus. Bytes received in a write sequence are gathered in a one-page staging buffer. The stop that closes the sequence starts a self-timed write cycle. During that cycle the received bytes are copied into the memory, and the block reports busy and accepts no input.

The block also owns the 16-bit address counter that survives between transfers. During a write it steps only the offset inside the 128-byte page, so a long burst comes back to the start of the same page. During a read it steps the full address across the whole array. A write-protect level at the stop cancels the commit.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy is low, no memory access is made, and the address counter is 0, so a first read without an address load returns the byte at address 0.
- R2: Each accepted byte is staged at the counter's low 7 bits. Those bits then increment, and the upper 9 bits never change during a write burst.
- R3: After offset 127 the next byte goes to offset 0 of the same page. When more than 128 bytes are sent, the last byte sent for an offset is the one kept.
- R4: Only offsets that received a byte are written to memory. Every other byte of the page keeps its old value.
- R5: A stop with at least one staged byte and write-protect low raises busy at the next clock edge for exactly WCYC cycles. The memory writes happen inside that window. A byte strobed in the same cycle as the stop is part of the commit.
- R6: While busy is high, address loads, byte strobes, read strobes, starts and stops have no effect.
- R7: Each read returns the byte at the counter and then adds one to all 16 bits, so address 0xFFFF is followed by 0x0000.
- R8: Between transfers the counter holds the last accessed address plus one (page-wrapped after a write), and a read without a load continues from there.
- R9: A stop while write-protect is high writes nothing, leaves busy low and discards the staged bytes.
- R10: A start that arrives while bytes are staged discards them, so a later stop commits nothing.
- R11: A stop with no staged bytes leaves busy low.
- R12: Read data is valid on the cycle after the accepted read strobe. A read strobe in the same cycle as an address load reads the loaded address. A byte strobe in the same cycle as a read strobe takes precedence, and the read is not made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_addr_i | input | 1 | Load the address counter from addr_i |
| addr_i | input | 16 | Address to load |
| wr_byte_i | input | 1 | Stage one write data byte |
| wr_data_i | input | 8 | Write data byte |
| rd_next_i | input | 1 | Read one byte at the counter |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | rd_data_o holds the requested byte |
| start_i | input | 1 | Start condition seen on the bus |
| stop_i | input | 1 | Stop condition seen on the bus |
| wp_i | input | 1 | Write-protect level |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after mem_re_o |

## Verification
Two functions can fall in the same cycle. The last data byte can arrive together with the stop that closes the sequence, and an address load can arrive together with a read or byte strobe. The bench drives both cases on the same clock edge. A behavioural model decides what the result must be: the late byte has to appear in memory after the commit, and the read has to return the byte at the newly loaded address. The model checks busy, read-valid and read data against the design on every clock.

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int PW   = 7,
  parameter int WCYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_byte_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_next_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          wp_i,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int PAGE = 1 << PW;
  localparam int CW   = $clog2(WCYC + 1);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] pbuf [PAGE];
  logic [PAGE-1:0] vld_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          rdv_q;

  logic [AW-1:0] addr_eff;
  logic [PW-1:0] sidx;
  logic          live, wr_go, rd_go, scan, commit;

  assign live     = !busy_q;
  assign addr_eff = ld_addr_i ? addr_i : addr_q;
  assign wr_go    = live && wr_byte_i;
  assign rd_go    = live && rd_next_i && !wr_byte_i;
  assign scan     = busy_q && (cnt_q < CW'(PAGE));
  assign sidx     = cnt_q[PW-1:0];
  assign commit   = live && stop_i && !wp_i && ((|vld_q) || wr_go);

  assign mem_we_o    = scan && vld_q[sidx];
  assign mem_re_o    = rd_go;
  assign mem_addr_o  = busy_q ? {addr_q[AW-1:PW], sidx} : addr_eff;
  assign mem_wdata_o = pbuf[sidx];
  assign rd_data_o   = mem_rdata_i;
  assign rd_valid_o  = rdv_q;
  assign busy_o      = busy_q;

  always_ff @(posedge clk) begin
    if (wr_go) pbuf[addr_eff[PW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rdv_q  <= 1'b0;
    end else begin
      rdv_q <= rd_go;
      if (busy_q) begin
        if (scan) vld_q[sidx] <= 1'b0;
        if (cnt_q == CW'(WCYC - 1)) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        if (ld_addr_i) addr_q <= addr_i;
        if (start_i) vld_q <= '0;
        if (wr_go) begin
          addr_q <= {addr_eff[AW-1:PW], addr_eff[PW-1:0] + PW'(1)};
          vld_q[addr_eff[PW-1:0]] <= 1'b1;
        end else if (rd_go) begin
          addr_q <= addr_eff + AW'(1);
        end
        if (stop_i) begin
          if (commit) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
          end else begin
            vld_q <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/page_commit_ctrl_chk.sv
module page_commit_ctrl_chk #(
  parameter int AW   = 16,
  parameter int PW   = 7,
  parameter int WCYC = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_addr_i,
  input logic          stop_i,
  input logic          wp_i,
  input logic          busy_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic          rd_valid_o,
  input logic [AW-1:0] mem_addr_o
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else        busy_run <= busy_o ? busy_run + 32'd1 : 32'd0;
  end

  p_we_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_run == 32'(WCYC));

  p_no_read_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !mem_re_o);

  p_same_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o[AW-1:PW] == $past(mem_addr_o[AW-1:PW]));

  p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> ((mem_re_o && !ld_addr_i) -> mem_addr_o == $past(mem_addr_o) + AW'(1)));

  p_wp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> rd_valid_o);
endmodule

bind page_commit_ctrl page_commit_ctrl_chk #(.AW(AW), .PW(PW), .WCYC(WCYC)) u_chk (.*);

// File: tb/page_commit_ctrl_bench.sv
module page_commit_ctrl_bench;
  localparam int WCYC = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld = 1'b0, wr = 1'b0, rd = 1'b0, st = 1'b0, sp = 1'b0, wp = 1'b0;
  logic [15:0] a_in = '0;
  logic [7:0]  d_in = '0;
  logic [7:0]  rd_data, mem_wdata, mem_rdata;
  logic        rd_valid, busy, mem_we, mem_re;
  logic [15:0] mem_addr;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  page_commit_ctrl #(.WCYC(WCYC)) u_page_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_addr_i(ld), .addr_i(a_in),
    .wr_byte_i(wr), .wr_data_i(d_in), .rd_next_i(rd),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .start_i(st), .stop_i(sp), .wp_i(wp), .busy_o(busy),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

  function automatic logic [7:0] seed_val(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  logic [7:0] bmem [int];
  always @(posedge clk) begin
    if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : seed_val(int'(mem_addr));
  end

  logic [7:0] rmem [int];
  logic [7:0] rbuf [int];
  int r_addr = 0, r_cnt = 0;
  logic r_rdv = 1'b0;
  logic [7:0] r_exp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      r_addr = 0; r_cnt = 0; r_rdv = 1'b0; rbuf.delete();
    end else begin
      r_rdv = 1'b0;
      if (r_cnt > 0) r_cnt--;
      else begin
        int ea;
        ea = ld ? int'(a_in) : r_addr;
        if (st) rbuf.delete();
        if (wr) begin
          rbuf[ea & 127] = d_in;
          r_addr = (ea & 'hFF80) | ((ea + 1) & 127);
        end else if (rd) begin
          r_exp  = rmem.exists(ea) ? rmem[ea] : seed_val(ea);
          r_rdv  = 1'b1;
          r_addr = (ea + 1) & 'hFFFF;
        end else if (ld) r_addr = ea;
        if (sp) begin
          if (rbuf.num() > 0 && !wp) begin
            foreach (rbuf[o]) rmem[(r_addr & 'hFF80) | o] = rbuf[o];
            r_cnt = WCYC;
          end
          rbuf.delete();
        end
      end
    end
  end

  task automatic check(logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      check(16'(busy), 16'(r_cnt > 0), "busy");
      check(16'(rd_valid), 16'(r_rdv), "rd_valid");
      if (r_rdv && rd_valid) check(16'(rd_data), 16'(r_exp), "rd_data");
    end
  end

  task automatic cyc(logic l, int a, logic w, int d, logic r, logic s_t, logic s_p);
    @(negedge clk);
    ld = l; a_in = 16'(a); wr = w; d_in = 8'(d); rd = r; st = s_t; sp = s_p;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wait_free();
    idle(1);
    while (busy) idle(1);
    idle(1);
  endtask

  task automatic wburst(int a, int n, int seed, logic stop_with_last);
    cyc(0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < n; i++)
      cyc(i == 0, a, 1, seed + i * 7, 0, 0, stop_with_last && (i == n - 1));
    if (!stop_with_last) cyc(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic rburst(int a, int n, logic load);
    cyc(0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < n; i++) cyc(load && i == 0, a, 0, 0, 1, 0, 0);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check(16'(busy), 16'd0, "busy in reset");
    check(16'(mem_we | mem_re), 16'd0, "mem idle in reset");
    rst_n = 1'b1;
    rburst(0, 2, 0);

    tag = "R2"; wburst('h1234, 5, 'h30, 0); tag = "R5"; wait_free();
    tag = "R8"; rburst(0, 3, 0);
    tag = "R4"; rburst('h1230, 16, 1);

    tag = "R5"; wburst('h4410, 4, 'h90, 1); wait_free();
    rburst('h4410, 5, 1);

    tag = "R3"; wburst('h207E, 131, 'h11, 0); wait_free();
    rburst('h2000, 128, 1); rburst('h2080, 2, 1);

    tag = "R6";
    wburst('h5000, 2, 'hA0, 0);
    for (int i = 0; i < 20; i++) cyc(i % 3 == 0, 'h5060, i % 2 == 0, 'hEE, i % 2 == 1, i == 5, i == 9);
    wait_free();
    rburst('h5000, 3, 1); rburst('h5060, 2, 1);

    tag = "R10";
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(1, 'h3000, 1, 'h77, 0, 0, 0); cyc(0, 0, 1, 'h78, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 0, 1); idle(4);
    rburst('h3000, 3, 1);

    tag = "R9";
    wp = 1'b1; wburst('h6000, 3, 'h44, 0); idle(4); wp = 1'b0;
    rburst('h6000, 3, 1);

    tag = "R11";
    cyc(0, 0, 0, 0, 0, 1, 0); cyc(1, 'h7000, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 1); idle(4);

    tag = "R7"; rburst('hFFFE, 4, 1);
    tag = "R12"; cyc(1, 'h1236, 0, 0, 1, 0, 0); cyc(0, 0, 1, 'h55, 1, 0, 0); idle(3);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule